// File: doc/BRIEF.md
# Update-Gated Phase Accumulator Core

This block is the phase engine of a numerically controlled oscillator whose control words are double-buffered. Software writes a tuning word and a phase offset into pending (shadow) registers. It writes them either directly or into one of eight profile slots, which three select pins choose between. None of these writes reaches the oscillator until an update strobe has been captured on the divided sync clock. At the next sync boundary the pending words move into the active registers. The accumulator keeps running across the switch and is never cleared.

Several copies of the core can share one system clock, one master reset, one divider realign pulse and one update strobe. They can be programmed one after another at any time, and they still all change frequency and phase on the same system clock count. The output is the top sixteen bits of the 32-bit accumulator plus the active phase offset. A sine lookup stage would take this value as its address.

The update control is a three-state machine. IDLE means nothing is pending. IDLE goes to ARMED when a strobe arrives on a cycle without a sync pulse. IDLE goes straight to CAPTURED when the strobe and the sync pulse arrive together. ARMED goes to CAPTURED on the next sync pulse. CAPTURED waits for the following sync pulse, performs the transfer on it, and then goes to IDLE. If a fresh strobe is present on that same edge, CAPTURED goes to ARMED instead. A strobe that arrives while in ARMED or CAPTURED merges into the update already pending.

Top module: `nco_update_core`

## Requirements
- R1: While `rst` is high, every pending, profile, active and accumulator register is cleared, the divider restarts at count 0, `phase_out` reads 0 and `sync_ce` is low.
- R2: `sync_ce` is high for exactly one system clock in every 16. It is high when the internal divider count is 15. A cycle with `sync_align` high forces the count to 0 at that edge, so the next `sync_ce` appears 15 edges later.
- R3: Writes to the pending registers do not change `phase_out` until a transfer takes place. Address 0 is the tuning word (32 bits). Address 1 is the phase offset (bits 15:0). Address 2 is control, and its bit 0 enables profile mode.
- R4: An `upd_req` pulse is captured by the first edge with `sync_ce` high, at or after the strobe. The active words are loaded at the next edge with `sync_ce` high, 16 cycles after the capture. The accumulator is not cleared at the load.
- R5: Any number of `upd_req` pulses that arrive before a capture, or between a capture and its load, produce a single transfer.
- R6: Profile slots sit at addresses 16+n (tuning word of slot n) and 24+n (phase offset of slot n), for n = 0..7. When profile mode is on at the load edge, the slot indexed by `prof_sel` at that edge supplies both active words. With profile mode on and `prof_sel` = 0, slot 0 is used.
- R7: On every clock after reset, the accumulator advances by the active tuning word, modulo 2^32.
- R8: `phase_out` equals accumulator bits 31:16 plus the active phase offset, modulo 2^16. An offset of 0x4000 places the output a quarter turn (90 degrees) ahead of an otherwise identical core.
- R9: Two cores that share clock, reset, `sync_align` and `upd_req` load their new words on the same clock, even when their pending registers were written on different cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous master reset, active high |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| prof_sel | input | 3 | Profile select pins |
| upd_req | input | 1 | Update strobe |
| sync_align | input | 1 | Restarts the sync divider at count 0 |
| sync_ce | output | 1 | Sync clock enable, one cycle in 16 |
| phase_out | output | 16 | Truncated phase plus offset |

## Verification
The hardest case to reach is a strobe that lands exactly on a load edge, or a burst of strobes split between the armed and captured phases. These cases test whether an update is merged, deferred or lost, and that decides the cycle on which the output slope changes. The stimulus drives short random strobe bursts across many divider phases. It also places directed pulses on the cycle just before and the cycle of a sync pulse. A cycle-level reference model in the bench, written from the requirements, predicts the output of two cores that are programmed at different moments but updated by one shared strobe.

// File: rtl/nco_pkg.sv
package nco_pkg;
    localparam int NPROF  = 8;
    localparam int PSEL_W = $clog2(NPROF);
    localparam int ADDR_W = PSEL_W + 2;

    localparam logic [ADDR_W-1:0] A_FTW  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_POW  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(2);

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_CAPTURED = 2'd2
    } upd_state_t;
endpackage

// File: rtl/nco_sync_div.sv
module nco_sync_div #(
    parameter int DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic align,
    output logic ce
);
    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || align) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign ce = (cnt_q == LAST);
endmodule

// File: rtl/nco_update_fsm.sv
module nco_update_fsm
    import nco_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd_req,
    input  logic       sync_ce,
    output logic       xfer,
    output upd_state_t state_o
);
    upd_state_t st_q, st_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        xfer = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (upd_req) begin
                    st_d = sync_ce ? ST_CAPTURED : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (sync_ce) begin
                    st_d = ST_CAPTURED;
                end
            end
            ST_CAPTURED: begin
                if (sync_ce) begin
                    xfer = 1'b1;
                    st_d = upd_req ? ST_ARMED : ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign state_o = st_q;
endmodule

// File: rtl/nco_shadow_bank.sv
module nco_shadow_bank
    import nco_pkg::*;
#(
    parameter int FTW_W = 32,
    parameter int POW_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]  wr_data,
    input  logic [PSEL_W-1:0] prof_sel,
    output logic [FTW_W-1:0]  nxt_ftw,
    output logic [POW_W-1:0]  nxt_pow
);
    logic [FTW_W-1:0] dir_ftw_q;
    logic [POW_W-1:0] dir_pow_q;
    logic             mode_q;
    logic [FTW_W-1:0] slot_ftw [NPROF];
    logic [POW_W-1:0] slot_pow [NPROF];

    wire in_slots = wr_addr[ADDR_W-1];
    wire pow_kind = wr_addr[ADDR_W-2];
    wire [PSEL_W-1:0] slot_idx = wr_addr[PSEL_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_ftw_q <= '0;
            dir_pow_q <= '0;
            mode_q    <= 1'b0;
        end else if (wr_en && !in_slots) begin
            if (wr_addr == A_FTW)  dir_ftw_q <= wr_data;
            if (wr_addr == A_POW)  dir_pow_q <= wr_data[POW_W-1:0];
            if (wr_addr == A_CTRL) mode_q    <= wr_data[0];
        end
    end

    for (genvar g = 0; g < NPROF; g++) begin : g_slot
        wire hit = wr_en && in_slots && (slot_idx == PSEL_W'(g));
        always_ff @(posedge clk) begin
            if (rst) begin
                slot_ftw[g] <= '0;
                slot_pow[g] <= '0;
            end else if (hit) begin
                if (pow_kind) slot_pow[g] <= wr_data[POW_W-1:0];
                else          slot_ftw[g] <= wr_data;
            end
        end
    end

    always_comb begin
        if (mode_q) begin
            nxt_ftw = slot_ftw[prof_sel];
            nxt_pow = slot_pow[prof_sel];
        end else begin
            nxt_ftw = dir_ftw_q;
            nxt_pow = dir_pow_q;
        end
    end
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W = 32,
    parameter int POW_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [ACC_W-1:0] nxt_ftw,
    input  logic [POW_W-1:0] nxt_pow,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] ftw_o,
    output logic [POW_W-1:0] pow_o,
    output logic [POW_W-1:0] phase_o
);
    logic [ACC_W-1:0] acc_q, ftw_q;
    logic [POW_W-1:0] pow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
            ftw_q <= '0;
            pow_q <= '0;
        end else begin
            acc_q <= acc_q + ftw_q;
            if (load) begin
                ftw_q <= nxt_ftw;
                pow_q <= nxt_pow;
            end
        end
    end

    assign acc_o   = acc_q;
    assign ftw_o   = ftw_q;
    assign pow_o   = pow_q;
    assign phase_o = acc_q[ACC_W-1 -: POW_W] + pow_q;
endmodule

// File: rtl/nco_update_core.sv
module nco_update_core
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int POW_W = 16,
    parameter int DIV   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [ACC_W-1:0]  wr_data,
    input  logic [PSEL_W-1:0] prof_sel,
    input  logic              upd_req,
    input  logic              sync_align,
    output logic              sync_ce,
    output logic [POW_W-1:0]  phase_out
);
    logic             xfer;
    upd_state_t       fsm_state;
    logic [ACC_W-1:0] nxt_ftw, acc_q, act_ftw;
    logic [POW_W-1:0] nxt_pow, act_pow;

    nco_sync_div #(.DIV(DIV)) u_div (
        .clk(clk), .rst(rst), .align(sync_align), .ce(sync_ce)
    );

    nco_update_fsm u_fsm (
        .clk(clk), .rst(rst), .upd_req(upd_req), .sync_ce(sync_ce),
        .xfer(xfer), .state_o(fsm_state)
    );

    nco_shadow_bank #(.FTW_W(ACC_W), .POW_W(POW_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prof_sel(prof_sel),
        .nxt_ftw(nxt_ftw), .nxt_pow(nxt_pow)
    );

    nco_phase_acc #(.ACC_W(ACC_W), .POW_W(POW_W)) u_acc (
        .clk(clk), .rst(rst), .load(xfer), .nxt_ftw(nxt_ftw),
        .nxt_pow(nxt_pow), .acc_o(acc_q), .ftw_o(act_ftw),
        .pow_o(act_pow), .phase_o(phase_out)
    );
endmodule

// File: rtl/nco_update_chk.sv
module nco_update_chk
    import nco_pkg::*;
#(
    parameter int ACC_W = 32,
    parameter int POW_W = 16,
    parameter int DIV   = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             sync_align,
    input logic             sync_ce,
    input logic             upd_req,
    input logic             xfer,
    input upd_state_t       st,
    input logic [ACC_W-1:0] acc,
    input logic [ACC_W-1:0] act_ftw,
    input logic [POW_W-1:0] act_pow
);
    localparam int GW = $clog2(DIV) + 1;
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (rst || sync_align || sync_ce) gap_q <= '0;
        else                               gap_q <= gap_q + 1'b1;
    end

    AST_CE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        sync_ce |-> (gap_q == GW'(DIV - 1))); // R2

    AST_HOLD_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> ($stable(act_ftw) && $stable(act_pow))); // R3

    AST_XFER_ON_CE: assert property (@(posedge clk) disable iff (rst)
        xfer |-> sync_ce); // R4

    AST_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (sync_ce && (st == ST_ARMED || (st == ST_IDLE && upd_req))) |=> (st == ST_CAPTURED)); // R5

    AST_ACC_STEP: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (acc == $past(acc + act_ftw))); // R7
endmodule

bind nco_update_core nco_update_chk #(.ACC_W(ACC_W), .POW_W(POW_W), .DIV(DIV)) u_chk (
    .clk(clk), .rst(rst), .sync_align(sync_align), .sync_ce(sync_ce),
    .upd_req(upd_req), .xfer(xfer), .st(fsm_state), .acc(acc_q),
    .act_ftw(act_ftw), .act_pow(act_pow)
);

// File: tb/sim_nco_update_core.sv
module sim_nco_update_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        upd_req = 1'b0;
    logic        sync_align = 1'b0;
    logic [2:0]  prof_sel = 3'd0;
    logic        we [2];
    logic [4:0]  wa [2];
    logic [31:0] wd [2];
    logic        ce [2];
    logic [15:0] ph [2];

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    nco_update_core u0 (.clk(clk), .rst(rst), .wr_en(we[0]), .wr_addr(wa[0]),
        .wr_data(wd[0]), .prof_sel(prof_sel), .upd_req(upd_req),
        .sync_align(sync_align), .sync_ce(ce[0]), .phase_out(ph[0]));
    nco_update_core u1 (.clk(clk), .rst(rst), .wr_en(we[1]), .wr_addr(wa[1]),
        .wr_data(wd[1]), .prof_sel(prof_sel), .upd_req(upd_req),
        .sync_align(sync_align), .sync_ce(ce[1]), .phase_out(ph[1]));

    // reference model state, values after the coming edge
    logic [31:0] m_acc [2], m_aftw [2], m_dftw [2];
    logic [15:0] m_apow [2], m_dpow [2];
    logic        m_mode [2];
    logic [3:0]  m_cnt [2];
    logic [1:0]  m_st [2];
    logic [31:0] m_pftw [2][8];
    logic [15:0] m_ppow [2][8];

    task automatic chk(string req, logic ok, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_step();
        for (int i = 0; i < 2; i++) begin
            if (rst) begin
                m_acc[i] = '0; m_aftw[i] = '0; m_apow[i] = '0;
                m_dftw[i] = '0; m_dpow[i] = '0; m_mode[i] = 1'b0;
                m_cnt[i] = '0; m_st[i] = 2'd0;
                for (int k = 0; k < 8; k++) begin
                    m_pftw[i][k] = '0; m_ppow[i][k] = '0;
                end
            end else begin
                logic tick;
                tick = (m_cnt[i] == 4'd15);
                m_acc[i] = m_acc[i] + m_aftw[i];
                if (m_st[i] == 2'd2 && tick) begin
                    if (m_mode[i]) begin
                        m_aftw[i] = m_pftw[i][prof_sel];
                        m_apow[i] = m_ppow[i][prof_sel];
                    end else begin
                        m_aftw[i] = m_dftw[i];
                        m_apow[i] = m_dpow[i];
                    end
                end
                case (m_st[i])
                    2'd0: if (upd_req) m_st[i] = tick ? 2'd2 : 2'd1;
                    2'd1: if (tick) m_st[i] = 2'd2;
                    default: if (tick) m_st[i] = upd_req ? 2'd1 : 2'd0;
                endcase
                if (we[i]) begin
                    if (wa[i][4]) begin
                        if (wa[i][3]) m_ppow[i][wa[i][2:0]] = wd[i][15:0];
                        else          m_pftw[i][wa[i][2:0]] = wd[i];
                    end else if (wa[i] == 5'd0) m_dftw[i] = wd[i];
                    else if (wa[i] == 5'd1) m_dpow[i] = wd[i][15:0];
                    else if (wa[i] == 5'd2) m_mode[i] = wd[i][0];
                end
                m_cnt[i] = sync_align ? 4'd0 : m_cnt[i] + 4'd1;
            end
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        model_step();
        @(posedge clk);
        #1;
        for (int i = 0; i < 2; i++) begin
            logic [15:0] e;
            e = m_acc[i][31:16] + m_apow[i];
            chk(cur_req, ph[i] === e, {16'h0, ph[i]}, {16'h0, e});
            chk("R2", ce[i] === (m_cnt[i] == 4'd15), {31'h0, ce[i]}, {31'h0, (m_cnt[i] == 4'd15)});
        end
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic wr(int i, logic [4:0] a, logic [31:0] d);
        we[i] = 1'b1; wa[i] = a; wd[i] = d;
        cyc();
        we[i] = 1'b0;
    endtask

    task automatic strobe();
        upd_req = 1'b1;
        cyc();
        upd_req = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        run(3);
        rst = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 2; i++) begin
            we[i] = 1'b0; wa[i] = '0; wd[i] = '0;
        end
        // R1: reset state
        cur_req = "R1";
        do_reset();
        chk("R1", ph[0] === 16'h0 && ce[0] === 1'b0, {16'h0, ph[0]}, 32'h0);
        // R2: divider period and realign
        cur_req = "R2";
        run(37);
        sync_align = 1'b1; cyc(); sync_align = 1'b0;
        run(20);
        // R3: pending writes invisible without a strobe
        cur_req = "R3";
        wr(0, 5'd0, 32'h0123_4567);
        wr(0, 5'd1, 32'h0000_2222);
        wr(1, 5'd0, 32'h0765_4321);
        run(40);
        chk("R3", ph[0] === 16'h0 && ph[1] === 16'h0, {ph[0], ph[1]}, 32'h0);
        // R4: strobe at various divider phases
        cur_req = "R4";
        strobe(); run(40);
        wr(0, 5'd0, 32'h0200_0000);
        run(7); strobe(); run(40);
        for (int k = 0; k < 16; k++) begin
            wr(1, 5'd0, 32'h0001_0000 * (k + 1));
            run(k); strobe(); run(35);
        end
        // R5: bursts of strobes merge
        cur_req = "R5";
        for (int k = 0; k < 6; k++) begin
            wr(0, 5'd1, $urandom);
            strobe(); run(3); strobe(); run(k * 3); strobe();
            run(20 + k); strobe(); run(40);
        end
        // R6: profile mode
        cur_req = "R6";
        for (int s = 0; s < 8; s++) begin
            wr(0, 5'(16 + s), 32'h0100_0000 + 32'(s) * 32'h0011_0000);
            wr(0, 5'(24 + s), 32'(s) * 32'h0000_0800);
            wr(1, 5'(16 + s), $urandom);
            wr(1, 5'(24 + s), $urandom);
        end
        wr(0, 5'd2, 32'h1); wr(1, 5'd2, 32'h1);
        prof_sel = 3'd0; strobe(); run(40);
        for (int s = 1; s < 8; s++) begin
            prof_sel = 3'(s); strobe(); run(36);
        end
        prof_sel = 3'd0;
        // R8 / R9: quarter-turn offset, shared strobe after staggered writes
        cur_req = "R8";
        do_reset();
        wr(0, 5'd0, 32'h0010_0000); run(5);
        wr(0, 5'd1, 32'h0000_4000); run(11);
        wr(1, 5'd0, 32'h0010_0000);
        run(3); strobe(); run(40);
        chk("R8", 16'(ph[0] - ph[1]) === 16'h4000, {16'h0, 16'(ph[0] - ph[1])}, 32'h4000);
        for (int k = 0; k < 20; k++) begin
            cyc();
            chk("R9", 16'(ph[0] - ph[1]) === 16'h4000, {16'h0, 16'(ph[0] - ph[1])}, 32'h4000);
        end
        // R7: random mix
        cur_req = "R7";
        for (int k = 0; k < 3000; k++) begin
            for (int i = 0; i < 2; i++) begin
                we[i] = ($urandom % 5) == 0;
                case ($urandom % 4)
                    0: wa[i] = 5'd0;
                    1: wa[i] = 5'd1;
                    2: wa[i] = 5'd2;
                    default: wa[i] = 5'(16 + $urandom % 16);
                endcase
                wd[i] = $urandom;
            end
            upd_req = ($urandom % 12) == 0;
            sync_align = ($urandom % 400) == 0;
            prof_sel = 3'($urandom % 8);
            cyc();
        end
        we[0] = 1'b0; we[1] = 1'b0; upd_req = 1'b0; sync_align = 1'b0;
        run(5);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule